// File: doc/BRIEF.md
# Cycle-Stealing Framebuffer Arbiter

This block lets a display scan-out engine and a host CPU share one single-port SRAM with 16-bit words. The display has no memory of its own. It takes one SRAM cycle for every 16 output bits, loads the word into a holding register, and moves it into a shift register that sends one bit per clock as an unbroken serial stream. The CPU uses the SRAM in every other cycle. The CPU is never refused. When its request lands in the same cycle as a display fetch, the CPU is stalled for that cycle by a wait signal and its access completes in the next cycle.

The display fetch is requested while the current word is still shifting, at a bit position set by a parameter. This leaves a few bit times of slack before the shifter runs dry. Scan addresses start at a programmable base, advance by one word per fetch, and return to the base after a programmable number of words, which together make one frame. A sticky underflow flag records any word boundary that arrives with no next word waiting. It is the evidence that the stream broke.

The SRAM is assumed to answer reads in the same cycle as the address. The clock is the bit clock.

Top module: `fb_steal_arbiter`

## Requirements
- R1: After reset, `ser_valid`, `cpu_wait` and `underflow` are all 0.
- R2: After `scan_en` rises, the first fetch happens in the same cycle. `ser_valid` goes high after the second rising edge, and the first bit sent is bit 15 of the word at `fb_base`.
- R3: While `scan_en` stays high, the stream sends each word MSB first, 16 bits per word, with `ser_valid` never dropping between words.
- R4: Successive words come from `fb_base`, `fb_base+1`, and so on up to `fb_base+frame_words-1`. The sequence then starts again at `fb_base`.
- R5: The display fetch has priority. `cpu_wait` is high in exactly those cycles in which `cpu_req` is high and a display fetch owns the SRAM. It is asserted combinationally in that cycle.
- R6: `cpu_wait` never stays high for two consecutive cycles. The stalled access completes in the next cycle, and read data appears on `cpu_rdata` in the cycle in which `cpu_wait` is low.
- R7: While `scan_en` is low, a CPU access never waits. Its address and write strobe pass straight to the SRAM.
- R8: CPU writes honour byte enables: `cpu_be[0]` writes bits 7:0 and `cpu_be[1]` writes bits 15:8. A write with both enables low leaves the word unchanged.
- R9: `underflow` is set, and stays set until reset, when a word boundary is reached with no word in the holding register. With a fetch point of bit 14 or earlier, it never sets.
- R10: Once the stream is running, there is exactly one display fetch per 16 bit times. A CPU request held high for 64 bit times therefore sees exactly 4 wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one output bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Starts (high) or stops and clears (low) the scan-out |
| fb_base | input | AW | First word address of the frame |
| frame_words | input | AW | Number of words in one frame |
| cpu_req | input | 1 | CPU access request, held until the access completes |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_be | input | DW/8 | Byte enables for writes, bit 0 selects bits 7:0 |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, valid while a read is granted |
| cpu_wait | output | 1 | Stalls the CPU for the current cycle |
| mem_addr | output | AW | SRAM word address |
| mem_we | output | 1 | SRAM write strobe, taken at the rising edge |
| mem_be | output | DW/8 | SRAM byte enables |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, same cycle as the address |
| ser_out | output | 1 | Serial pixel bit |
| ser_valid | output | 1 | High while the stream is running |
| underflow | output | 1 | Sticky flag for a broken stream |

## Verification
`cpu_wait` and `cpu_rdata` are combinational, so the bench samples them one time unit after driving the request at the falling edge, in the same cycle. The access itself completes at the following rising edge. The stream outputs come from registers. The bench samples `ser_valid` one and two rising edges after raising `scan_en`, and expects it low and then high. From then on it takes one bit at every falling edge and compares each group of 16 bits with the frame word it has computed. The underflow case is checked on a second instance whose fetch point is the last bit, where the first word boundary falls 18 edges after the start.

// File: rtl/fbsa_pkg.sv
package fbsa_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_SCAN = 2'd2
  } mem_owner_e;

  // The display fetch always wins the single SRAM port.
  function automatic mem_owner_e pick_owner(input logic scan_req, input logic host_req);
    if (scan_req)      return OWN_SCAN;
    else if (host_req) return OWN_CPU;
    else               return OWN_NONE;
  endfunction

endpackage

// File: rtl/fbsa_scan_addr.sv
module fbsa_scan_addr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] words,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [AW-1:0] idx;

  // A frame of zero words is treated as one word.
  function automatic logic at_frame_end(input logic [AW-1:0] i, input logic [AW-1:0] n);
    logic [AW:0] nxt;
    nxt = {1'b0, i} + {{AW{1'b0}}, 1'b1};
    return nxt >= {1'b0, n};
  endfunction

  assign last = at_frame_end(idx, words);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      idx  <= '0;
    end else if (clear) begin
      addr <= base;
      idx  <= '0;
    end else if (step) begin
      if (last) begin
        addr <= base;
        idx  <= '0;
      end else begin
        addr <= addr + 1'b1;
        idx  <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbsa_shifter.sv
module fbsa_shifter #(
  parameter int DW       = 16,
  parameter int FETCH_AT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  output logic          need_fill,
  output logic          load_edge,
  output logic          hold_valid,
  output logic          ser_out,
  output logic          ser_valid,
  output logic          underflow
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] LEAD_BIT = CW'(FETCH_AT);

  logic [DW-1:0] shreg;
  logic [DW-1:0] hold;
  logic [CW-1:0] bitcnt;
  logic          active;
  logic          ufl;

  function automatic logic fetch_window(input logic act, input logic [CW-1:0] cnt);
    return !act || (cnt >= LEAD_BIT);
  endfunction

  assign load_edge = run && active && (bitcnt == LAST_BIT);
  assign need_fill = run && !hold_valid && fetch_window(active, bitcnt);
  assign ser_out   = shreg[DW-1];
  assign ser_valid = active;
  assign underflow = ufl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      hold       <= '0;
      bitcnt     <= '0;
      active     <= 1'b0;
      hold_valid <= 1'b0;
      ufl        <= 1'b0;
    end else if (!run) begin
      shreg      <= '0;
      bitcnt     <= '0;
      active     <= 1'b0;
      hold_valid <= 1'b0;
    end else begin
      if (load_edge) begin
        bitcnt <= '0;
        if (hold_valid) begin
          shreg      <= hold;
          hold_valid <= 1'b0;
        end else begin
          ufl    <= 1'b1;
          active <= 1'b0;
        end
      end else if (active) begin
        shreg  <= {shreg[DW-2:0], 1'b0};
        bitcnt <= bitcnt + 1'b1;
      end else if (hold_valid) begin
        shreg      <= hold;
        active     <= 1'b1;
        bitcnt     <= '0;
        hold_valid <= 1'b0;
      end
      if (fill) begin
        hold       <= fill_data;
        hold_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbsa_arbiter.sv
module fbsa_arbiter
  import fbsa_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int BEW = 2
) (
  input  logic           scan_req,
  input  logic [AW-1:0]  scan_addr,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [BEW-1:0] cpu_be,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_wait,
  output logic           fetch_go,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [BEW-1:0] mem_be,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);

  mem_owner_e owner;
  logic       host_go;

  always_comb begin
    owner     = pick_owner(scan_req, cpu_req);
    fetch_go  = (owner == OWN_SCAN);
    host_go   = (owner == OWN_CPU);
    cpu_wait  = cpu_req && fetch_go;
    mem_addr  = fetch_go ? scan_addr : cpu_addr;
    mem_we    = host_go && cpu_we;
    mem_be    = host_go ? cpu_be : '1;
    mem_wdata = cpu_wdata;
    cpu_rdata = (host_go && !cpu_we) ? mem_rdata : '0;
  end

endmodule

// File: rtl/fb_steal_arbiter.sv
module fb_steal_arbiter #(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int FETCH_AT = DW - 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic [AW-1:0]   fb_base,
  input  logic [AW-1:0]   frame_words,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [DW/8-1:0] cpu_be,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_wait,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            ser_out,
  output logic            ser_valid,
  output logic            underflow
);

  localparam int BEW = DW / 8;

  // Named internal events, also observed by the bound checker.
  logic          need_fill;
  logic          fetch_go;
  logic          load_edge;
  logic          hold_valid;
  logic          last_word;
  logic [AW-1:0] scan_addr;

  fbsa_scan_addr #(.AW(AW)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!scan_en),
    .step  (fetch_go),
    .base  (fb_base),
    .words (frame_words),
    .addr  (scan_addr),
    .last  (last_word)
  );

  fbsa_arbiter #(.AW(AW), .DW(DW), .BEW(BEW)) u_arb (
    .scan_req  (need_fill),
    .scan_addr (scan_addr),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_be    (cpu_be),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_wait  (cpu_wait),
    .fetch_go  (fetch_go),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  fbsa_shifter #(.DW(DW), .FETCH_AT(FETCH_AT)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (scan_en),
    .fill       (fetch_go),
    .fill_data  (mem_rdata),
    .need_fill  (need_fill),
    .load_edge  (load_edge),
    .hold_valid (hold_valid),
    .ser_out    (ser_out),
    .ser_valid  (ser_valid),
    .underflow  (underflow)
  );

endmodule

// File: rtl/fbsa_checker.sv
module fbsa_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_wait,
  input logic [AW-1:0] cpu_addr,
  input logic [AW-1:0] mem_addr,
  input logic          fetch_go,
  input logic          hold_valid,
  input logic          last_word,
  input logic [AW-1:0] scan_addr,
  input logic [AW-1:0] fb_base,
  input logic          underflow,
  input logic          load_edge
);

  assert_wait_on_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (cpu_req && fetch_go));

  assert_wait_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> !cpu_wait);

  assert_cpu_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_wait) |-> (mem_addr == cpu_addr));

  assert_fetch_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> hold_valid);

  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && last_word) |=> (scan_addr == $past(fb_base)));

  assert_scan_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !last_word) |=> (scan_addr == $past(scan_addr) + 1'b1));

  assert_underflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $past(load_edge && !hold_valid));

  assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

endmodule

bind fb_steal_arbiter fbsa_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_wait   (cpu_wait),
  .cpu_addr   (cpu_addr),
  .mem_addr   (mem_addr),
  .fetch_go   (fetch_go),
  .hold_valid (hold_valid),
  .last_word  (last_word),
  .scan_addr  (scan_addr),
  .fb_base    (fb_base),
  .underflow  (underflow),
  .load_edge  (load_edge)
);

// File: tb/fb_steal_arbiter_test.sv
module fb_steal_arbiter_test;

  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0;
  logic          scan_en_late = 1'b0;
  logic [AW-1:0] fb_base = 8'h20;
  logic [AW-1:0] frame_words = 8'd5;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [1:0]    cpu_be = 2'b00;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_wait;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [1:0]    mem_be;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          ser_out, ser_valid, underflow;

  logic [DW-1:0] l_rdata, l_wdata;
  logic          l_wait, l_we, l_out, l_valid, l_ufl;
  logic [AW-1:0] l_addr;
  logic [1:0]    l_be;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  function automatic logic [15:0] pat(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b, ~b};
  endfunction

  logic [DW-1:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = pat(i);
  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) ram[mem_addr][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) ram[mem_addr][15:8] <= mem_wdata[15:8];
    end
  end

  fb_steal_arbiter #(.AW(AW), .DW(DW), .FETCH_AT(12)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .fb_base(fb_base),
    .frame_words(frame_words), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ser_out(ser_out), .ser_valid(ser_valid),
    .underflow(underflow)
  );

  // Fetch point on the last bit: the first word boundary must underflow.
  fb_steal_arbiter #(.AW(AW), .DW(DW), .FETCH_AT(15)) uut_late (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en_late), .fb_base(fb_base),
    .frame_words(frame_words), .cpu_req(1'b0), .cpu_we(1'b0),
    .cpu_be(2'b00), .cpu_addr(8'h00), .cpu_wdata(16'h0000),
    .cpu_rdata(l_rdata), .cpu_wait(l_wait), .mem_addr(l_addr),
    .mem_we(l_we), .mem_be(l_be), .mem_wdata(l_wdata),
    .mem_rdata(16'hA5A5), .ser_out(l_out), .ser_valid(l_valid),
    .underflow(l_ufl)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Stream monitor: one bit per falling edge, a word every 16 bits.
  int            s_bits = 0;
  int            s_words = 0;
  logic [15:0]   s_acc = '0;
  logic          s_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ser_valid) begin
      s_acc = {s_acc[14:0], ser_out};
      s_bits++;
      if (s_bits == 16) begin
        check(s_acc == pat(int'(fb_base) + (s_words % int'(frame_words))),
              "R3/R4 stream word", s_acc,
              pat(int'(fb_base) + (s_words % int'(frame_words))));
        s_bits = 0;
        s_words++;
      end
    end else begin
      if (s_prev && scan_en) check(1'b0, "R3 gap in stream", 0, 1);
      s_bits = 0;
    end
    s_prev = ser_valid;
  end

  typedef struct packed {
    logic        we;
    logic [1:0]  be;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 8'h80, 16'h1234, 16'h0000},
    '{1'b0, 2'b00, 8'h80, 16'h0000, 16'h1234},
    '{1'b1, 2'b01, 8'h81, 16'hABCD, 16'h0000},
    '{1'b0, 2'b00, 8'h81, 16'h0000, 16'h81CD},
    '{1'b1, 2'b10, 8'h82, 16'h5566, 16'h0000},
    '{1'b0, 2'b00, 8'h82, 16'h0000, 16'h557D},
    '{1'b0, 2'b00, 8'h83, 16'h0000, 16'h837C},
    '{1'b1, 2'b00, 8'h84, 16'hFFFF, 16'h0000},
    '{1'b0, 2'b00, 8'h84, 16'h0000, 16'h847B}
  };

  task automatic cpu_op(input vec_t v, input bit idle_scan);
    int waits;
    waits = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = v.we; cpu_be = v.be;
    cpu_addr = v.addr; cpu_wdata = v.wd;
    #1;
    while (cpu_wait) begin
      waits++;
      @(negedge clk);
      #1;
    end
    if (!v.we) check(cpu_rdata == v.exp, "R8/R6 read data", cpu_rdata, v.exp);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (idle_scan) check(waits == 0, "R7 no wait without scan", waits, 0);
    else           check(waits <= 1, "R6 wait length", waits, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int waits;
    repeat (4) @(negedge clk);
    check(ser_valid == 1'b0, "R1 ser_valid in reset", ser_valid, 0);
    check(cpu_wait == 1'b0, "R1 cpu_wait in reset", cpu_wait, 0);
    check(underflow == 1'b0, "R1 underflow in reset", underflow, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk with the scan stopped: R7, R8.
    for (int i = 0; i < NV; i++) cpu_op(VECS[i], 1'b1);

    // Start the scan on both instances: R2.
    @(negedge clk);
    scan_en = 1'b1;
    scan_en_late = 1'b1;
    @(negedge clk);
    check(ser_valid == 1'b0, "R2 not valid after one edge", ser_valid, 0);
    @(negedge clk);
    check(ser_valid == 1'b1, "R2 valid after two edges", ser_valid, 1);
    check(ser_out == pat(int'(fb_base))[15], "R2 first bit", ser_out, pat(int'(fb_base))[15]);

    // Table walk again while fetches run: R6, R8.
    for (int i = 0; i < NV; i++) cpu_op(VECS[i], 1'b0);

    // Held request over 64 bit times: R5, R10.
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h83;
    waits = 0;
    for (int c = 0; c < 64; c++) begin
      #1;
      if (cpu_wait) waits++;
      else check(cpu_rdata == 16'h837C, "R5 read between fetches", cpu_rdata, 16'h837C);
      @(negedge clk);
    end
    cpu_req = 1'b0;
    check(waits == 4, "R10 one fetch per 16 bits", waits, 4);

    repeat (120) @(negedge clk);
    check(s_words >= 12, "R4 frame wrapped", s_words, 12);
    check(underflow == 1'b0, "R9 no underflow with slack", underflow, 0);
    check(l_ufl == 1'b1, "R9 underflow without slack", l_ufl, 1);

    // Stop the scan: the stream ends, the underflow flag stays.
    scan_en = 1'b0;
    scan_en_late = 1'b0;
    repeat (2) @(negedge clk);
    check(ser_valid == 1'b0, "R3 stream stops", ser_valid, 0);
    check(l_ufl == 1'b1, "R9 underflow sticky", l_ufl, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule